// File: doc/BRIEF.md
# Integer Bit-Manipulation Execution Unit

This unit performs one bit-level integer operation per clock. The operation is chosen by a 4-bit opcode. The operations are: counting set bits in a 32-bit word or a 64-bit word, reading and writing a bitfield, three kinds of leading/trailing bit search, mirroring a word, add with carry-in, subtract with borrow-in, and a lane-prefix count over a 64-bit mask.

The prefix count is used for stream compaction. Each lane takes the number of active lanes below itself as its output slot.

Operands A, B and C are each 32 bits wide. Wherever a 64-bit value is needed, it is formed as {B, A}, with A as the low half. A result is registered one cycle after the issue cycle and is held unchanged while no operation is issued.

Top module: `bitops_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `out_valid`=0, `result`=0 and `flag`=0.
- R2: `out_valid` is a copy of `in_valid` delayed by one cycle. Results appear one cycle after issue. When `in_valid`=0, `result` and `flag` keep their values. The opcode values are:
  - 0: count32
  - 1: count64
  - 2: field get
  - 3: field put
  - 4: find high
  - 5: find low
  - 6: signed find high
  - 7: mirror
  - 8: add with carry
  - 9: subtract with borrow
  - 10: lane prefix
- R3: Opcode 0 returns the number of ones in A. Opcode 1 returns the number of ones in {B, A}.
- R4: Field get (opcode 2) takes the offset from C[4:0] and the width from C[12:8], both therefore modulo 32. It returns bits A[off+i] for i < width, zero-extended. Bits at positions 32 and above read as 0. A width of 0 returns 0.
- R5: Field put (opcode 3) writes the low `width` bits of B into A starting at bit `off`, using the same C fields as R4. Field bits that fall above bit 31 are dropped. All bits of A outside the field are returned unchanged.
- R6: Find high (opcode 4) returns the index of the most significant set bit of A. Find low (opcode 5) returns the index of the least significant set bit. If A is 0, both return 0xFFFFFFFF.
- R7: Signed find high (opcode 6) returns the index of the most significant bit in A[30:0] that differs from A[31]. If no bit differs, it returns 0xFFFFFFFF.
- R8: Mirror (opcode 7) returns A with bit i moved to bit 31-i.
- R9: Opcode 8 returns A+B+`carry_in`, with `flag` set to the carry out of bit 31. Opcode 9 returns A-B-`carry_in`, with `flag` set to the borrow out.
- R10: Lane prefix (opcode 10) returns the number of set bits of the mask {B, A} in positions below the lane index C[5:0].
- R11: `flag` is 0 for every opcode other than 8 and 9. Opcodes 11 to 15 return `result`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 4 | Opcode |
| opnd_a | input | 32 | Operand A (low half of 64-bit values) |
| opnd_b | input | 32 | Operand B (high half of 64-bit values) |
| opnd_c | input | 32 | Operand C: field offset/width, or lane index |
| carry_in | input | 1 | Carry or borrow into bit 0 |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Operation result |
| flag | output | 1 | Carry or borrow out |

## Verification
Two conditions are hard to reach with random operands:
- Boundary words that random values almost never produce. These are A equal to 0 or to all ones for the searches, and 0x80000000 for the signed search.
- Field and lane settings at their edges. These are a width of 0, a field that runs past bit 31, and lane indices 0 and 63.

Directed vectors drive each of these conditions. A long random run then crosses all opcodes, including unused ones, with idle cycles mixed in. A behavioural model in the bench checks every cycle.

// File: rtl/bitops_pkg.sv
// Shared opcode encoding and data width for the bit-manipulation unit.
package bitops_pkg;
    localparam int DW = 32;

    typedef enum logic [3:0] {
        OP_COUNT32     = 4'd0,
        OP_COUNT64     = 4'd1,
        OP_FIELD_GET   = 4'd2,
        OP_FIELD_PUT   = 4'd3,
        OP_FIND_HI     = 4'd4,
        OP_FIND_LO     = 4'd5,
        OP_FIND_HI_SGN = 4'd6,
        OP_MIRROR      = 4'd7,
        OP_ADD_CARRY   = 4'd8,
        OP_SUB_BORROW  = 4'd9,
        OP_LANE_PREFIX = 4'd10
    } op_e;
endpackage

// File: rtl/bitops_count.sv
// Counts the set bits of a W-bit vector.
// Assumes: W >= 1. The logic is combinational; the synthesis tool builds the adder tree.
module bitops_count #(
    parameter int W  = 32,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] ones
);
    // Sum the bits of the vector.
    always_comb begin
        ones = '0;
        for (int i = 0; i < W; i++) begin
            ones = ones + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/bitops_find.sv
// Priority search: returns the index of the highest or the lowest set bit.
// Assumes: W is a power of two. `found` is low when the vector is zero.
module bitops_find #(
    parameter int W  = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    input  logic          from_low,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan the bits; the last match written wins, so the scan order picks the end searched.
    always_comb begin
        idx   = '0;
        found = |vec;
        if (from_low) begin
            for (int i = W - 1; i >= 0; i--) begin
                if (vec[i]) idx = IW'(i);
            end
        end else begin
            for (int i = 0; i < W; i++) begin
                if (vec[i]) idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/bitops_field.sv
// Bitfield read and write on a W-bit word.
// Assumes: offset and width each arrive as log2(W) bits, so both are taken modulo W.
module bitops_field #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  base,
    input  logic [W-1:0]  src,
    input  logic [SW-1:0] off,
    input  logic [SW-1:0] wid,
    output logic [W-1:0]  got,
    output logic [W-1:0]  put
);
    logic [W-1:0] low_mask;
    logic [W-1:0] place_mask;

    // Build the width mask and move it to the field position.
    always_comb begin
        low_mask   = (W'(1) << wid) - W'(1);
        place_mask = low_mask << off;
    end

    // Extract the field zero-extended, and merge the source field into the base word.
    always_comb begin
        got = (base >> off) & low_mask;
        put = (base & ~place_mask) | ((src << off) & place_mask);
    end
endmodule

// File: rtl/bitops_unit.sv
// Bit-manipulation execution unit: one opcode-selected operation per cycle.
// The result is registered with one cycle of latency and held while idle.
// Assumes: 64-bit values are {opnd_b, opnd_a}. The field offset is in opnd_c[4:0],
// the field width in opnd_c[12:8], and the lane index in opnd_c[5:0].
module bitops_unit
    import bitops_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] opnd_c,
    input  logic          carry_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          flag
);
    localparam int WW  = 2 * DW;
    localparam int SW  = $clog2(DW);
    localparam int LW  = $clog2(WW);
    localparam int C1W = $clog2(DW + 1);
    localparam int C2W = $clog2(WW + 1);

    op_e           opc;
    logic [WW-1:0] pair;
    logic [WW-1:0] lane_mask;
    logic [WW-1:0] wide_vec;
    logic [C1W-1:0] cnt_narrow;
    logic [C2W-1:0] cnt_wide;
    logic [DW-1:0] search_vec;
    logic          search_hit;
    logic [SW-1:0] search_idx;
    logic [DW-1:0] field_got;
    logic [DW-1:0] field_put;
    logic [DW-1:0] mirrored;
    logic [DW:0]   sum_ext;
    logic [DW:0]   diff_ext;
    logic [DW-1:0] res_next;
    logic          flag_next;

    // Decode the opcode and form the 64-bit operand views.
    always_comb begin
        opc       = op_e'(op);
        pair      = {opnd_b, opnd_a};
        lane_mask = (WW'(1) << opnd_c[LW-1:0]) - WW'(1);
        wide_vec  = (opc == OP_LANE_PREFIX) ? (pair & lane_mask) : pair;
    end

    bitops_count #(.W(DW)) u_cnt_narrow (.vec(opnd_a),   .ones(cnt_narrow));
    bitops_count #(.W(WW)) u_cnt_wide   (.vec(wide_vec), .ones(cnt_wide));

    // Select the search input: for the signed form, search for bits that differ from the sign.
    always_comb begin
        if (opc == OP_FIND_HI_SGN)
            search_vec = (opnd_a ^ {DW{opnd_a[DW-1]}}) & {1'b0, {(DW-1){1'b1}}};
        else
            search_vec = opnd_a;
    end

    bitops_find #(.W(DW)) u_find (
        .vec      (search_vec),
        .from_low (opc == OP_FIND_LO),
        .found    (search_hit),
        .idx      (search_idx)
    );

    bitops_field #(.W(DW)) u_field (
        .base (opnd_a),
        .src  (opnd_b),
        .off  (opnd_c[SW-1:0]),
        .wid  (opnd_c[8 +: SW]),
        .got  (field_got),
        .put  (field_put)
    );

    // Mirror the operand bit order.
    for (genvar i = 0; i < DW; i++) begin : g_mirror
        assign mirrored[i] = opnd_a[DW-1-i];
    end

    // Add with carry and subtract with borrow, each one bit wider to catch the overflow bit.
    always_comb begin
        sum_ext  = {1'b0, opnd_a} + {1'b0, opnd_b} + (DW+1)'(carry_in);
        diff_ext = {1'b0, opnd_a} - {1'b0, opnd_b} - (DW+1)'(carry_in);
    end

    // Pick the result and flag for the issued opcode.
    always_comb begin
        res_next  = '0;
        flag_next = 1'b0;
        case (opc)
            OP_COUNT32:     res_next = DW'(cnt_narrow);
            OP_COUNT64,
            OP_LANE_PREFIX: res_next = DW'(cnt_wide);
            OP_FIELD_GET:   res_next = field_got;
            OP_FIELD_PUT:   res_next = field_put;
            OP_FIND_HI,
            OP_FIND_LO,
            OP_FIND_HI_SGN: res_next = search_hit ? DW'(search_idx) : '1;
            OP_MIRROR:      res_next = mirrored;
            OP_ADD_CARRY: begin
                res_next  = sum_ext[DW-1:0];
                flag_next = sum_ext[DW];
            end
            OP_SUB_BORROW: begin
                res_next  = diff_ext[DW-1:0];
                flag_next = diff_ext[DW];
            end
            default: res_next = '0;
        endcase
    end

    // Output register: clear on reset, load on issue, hold while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= res_next;
                flag   <= flag_next;
            end
        end
    end
endmodule

// File: rtl/bitops_unit_chk.sv
// Property checker for bitops_unit; attached through the bind at the end of this file.
module bitops_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [31:0] opnd_c,
    input logic        carry_in,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        flag
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == 32'd0 && !flag));

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flag)));

    assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd0) |=> (result <= 32'd32));

    assert_zero_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd2 && opnd_c[12:8] == 5'd0) |=> (result == 32'd0));

    assert_find_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 4'd4 || op == 4'd5) && opnd_a == 32'd0) |=> (result == 32'hFFFF_FFFF));

    assert_find_low_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd5 && opnd_a != 32'd0)
        |=> (result < 32'd32 && (($past(opnd_a) >> result[4:0]) & 32'd1) == 32'd1));

    assert_prefix_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd10) |=> (result <= {26'd0, $past(opnd_c[5:0])}));

    assert_flag_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != 4'd8 && op != 4'd9) |=> !flag);
endmodule

bind bitops_unit bitops_unit_chk u_chk (.*);

// File: tb/bitops_unit_tb.sv
// Self-checking bench. A behavioural model computes the expected value of every
// operation; the outputs are compared on every falling clock edge.
module bitops_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op;
    logic [31:0] opnd_a, opnd_b, opnd_c;
    logic        carry_in;
    logic        out_valid;
    logic [31:0] result;
    logic        flag;

    int checks = 0;
    int fails  = 0;
    logic        exp_valid;
    logic [31:0] exp_res;
    logic        exp_flag;
    logic [3:0]  exp_op;
    bit          done = 0;

    always #2 clk = ~clk;

    bitops_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .carry_in(carry_in),
        .out_valid(out_valid), .result(result), .flag(flag)
    );

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0, 4'd1: return "R3";
            4'd2:       return "R4";
            4'd3:       return "R5";
            4'd4, 4'd5: return "R6";
            4'd6:       return "R7";
            4'd7:       return "R8";
            4'd8, 4'd9: return "R9";
            4'd10:      return "R10";
            default:    return "R11";
        endcase
    endfunction

    // Behavioural model of the requirements.
    task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] c, input logic ci,
                         output logic [31:0] r, output logic f);
        int n, off, wid, lane;
        logic [63:0] m;
        logic [32:0] w;
        r = 32'd0; f = 1'b0; n = 0;
        off = int'(c[4:0]); wid = int'(c[12:8]); lane = int'(c[5:0]);
        m = {b, a};
        case (o)
            4'd0: begin for (int i = 0; i < 32; i++) n += int'(a[i]); r = 32'(n); end
            4'd1: begin for (int i = 0; i < 64; i++) n += int'(m[i]); r = 32'(n); end
            4'd2: for (int i = 0; i < wid; i++) if (off + i < 32) r[i] = a[off + i];
            4'd3: begin
                r = a;
                for (int i = 0; i < wid; i++) if (off + i < 32) r[off + i] = b[i];
            end
            4'd4: begin r = '1; for (int i = 0; i < 32; i++) if (a[i]) r = 32'(i); end
            4'd5: begin r = '1; for (int i = 31; i >= 0; i--) if (a[i]) r = 32'(i); end
            4'd6: begin r = '1; for (int i = 0; i < 31; i++) if (a[i] != a[31]) r = 32'(i); end
            4'd7: for (int i = 0; i < 32; i++) r[i] = a[31 - i];
            4'd8: begin w = {1'b0, a} + {1'b0, b} + {32'd0, ci}; r = w[31:0]; f = w[32]; end
            4'd9: begin w = {1'b0, a} - {1'b0, b} - {32'd0, ci}; r = w[31:0]; f = w[32]; end
            4'd10: begin for (int i = 0; i < lane; i++) n += int'(m[i]); r = 32'(n); end
            default: ;
        endcase
    endtask

    task automatic compare(input string req);
        checks++;
        if (out_valid !== exp_valid || result !== exp_res || flag !== exp_flag) begin
            fails++;
            $display("FAIL %s op=%0d: got valid=%b result=%h flag=%b, expected valid=%b result=%h flag=%b",
                     req, exp_op, out_valid, result, flag, exp_valid, exp_res, exp_flag);
        end
    endtask

    // Check the previous cycle's operation, then drive the next one. Called just after a falling edge.
    task automatic step(input logic v, input logic [3:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c, input logic ci);
        logic [31:0] r;
        logic f;
        compare(exp_valid ? req_of(exp_op) : "R2");
        in_valid = v; op = o; opnd_a = a; opnd_b = b; opnd_c = c; carry_in = ci;
        exp_valid = v;
        exp_op = o;
        if (v) begin
            model(o, a, b, c, ci, r, f);
            exp_res = r; exp_flag = f;
        end
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; op = 4'd8;
        opnd_a = '1; opnd_b = '1; opnd_c = '0; carry_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs cleared by reset even with an operation presented
        exp_valid = 1'b0; exp_res = 32'd0; exp_flag = 1'b0; exp_op = 4'd8;
        compare("R1");
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        // R3 population counts
        step(1, 4'd0, 32'd0, 32'd0, 32'd0, 0);
        step(1, 4'd0, 32'hFFFF_FFFF, 32'd0, 32'd0, 0);
        step(1, 4'd1, 32'hFFFF_FFFF, 32'h8000_0001, 32'd0, 0);
        // R4 field get: zero width, field past bit 31, normal field
        step(1, 4'd2, 32'hDEAD_BEEF, 32'd0, 32'h0000_0004, 0);
        step(1, 4'd2, 32'hF000_0000, 32'd0, 32'h0000_081C, 0);
        step(1, 4'd2, 32'h1234_5678, 32'd0, 32'h0000_0C08, 0);
        // R5 field put: normal, past bit 31, zero width
        step(1, 4'd3, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0804, 0);
        step(1, 4'd3, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_101C, 0);
        step(1, 4'd3, 32'hA5A5_A5A5, 32'hFFFF_FFFF, 32'h0000_0010, 0);
        // R6 searches including no-hit
        step(1, 4'd4, 32'd0, 32'd0, 32'd0, 0);
        step(1, 4'd5, 32'd0, 32'd0, 32'd0, 0);
        step(1, 4'd4, 32'h0001_0010, 32'd0, 32'd0, 0);
        step(1, 4'd5, 32'h8000_0000, 32'd0, 32'd0, 0);
        // R7 signed search: all ones, all zeros, sign-only, mixed
        step(1, 4'd6, 32'hFFFF_FFFF, 32'd0, 32'd0, 0);
        step(1, 4'd6, 32'h0000_0000, 32'd0, 32'd0, 0);
        step(1, 4'd6, 32'h8000_0000, 32'd0, 32'd0, 0);
        step(1, 4'd6, 32'hFFF0_FFFF, 32'd0, 32'd0, 0);
        // R8 mirror
        step(1, 4'd7, 32'h0000_0001, 32'd0, 32'd0, 0);
        step(1, 4'd7, 32'h1234_5678, 32'd0, 32'd0, 0);
        // R9 carry and borrow edges
        step(1, 4'd8, 32'hFFFF_FFFF, 32'd0, 32'd0, 1);
        step(1, 4'd8, 32'h7FFF_FFFF, 32'd1, 32'd0, 0);
        step(1, 4'd9, 32'd0, 32'd0, 32'd0, 1);
        step(1, 4'd9, 32'd5, 32'd3, 32'd0, 1);
        // R10 lane prefix at lane 0, 63 and middle
        step(1, 4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 0);
        step(1, 4'd10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd63, 0);
        step(1, 4'd10, 32'hF0F0_F0F0, 32'h0000_0001, 32'd33, 0);
        // R11 unused opcodes with carry_in set; then R2 idle hold
        step(1, 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
        step(1, 4'd8, 32'hFFFF_FFFF, 32'd1, 32'd0, 0);
        step(0, 4'd0, 32'h1111_1111, 32'd0, 32'd0, 0);
        step(0, 4'd7, 32'h2222_2222, 32'd0, 32'd0, 1);
        step(1, 4'd11, 32'h1, 32'h1, 32'h1, 1);

        // Random run across all opcodes with idle cycles mixed in
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] ra, rb, rc;
            ra = $urandom; rb = $urandom; rc = $urandom;
            if (k % 7 == 0) ra = 32'd0;
            if (k % 11 == 0) ra = 32'hFFFF_FFFF;
            step(($urandom % 8) != 0, 4'($urandom % 16), ra, rb, rc, 1'($urandom));
        end
        step(0, 4'd0, 32'd0, 32'd0, 32'd0, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule